// File: doc/BRIEF.md
# Rename Register Budget Tracker

This block sits in the dispatch stage of an out-of-order core and keeps count of how many physical registers each rename register file has in use. Every logical register belongs to one owning file and costs a fixed number of physical registers when it is renamed. File 0 is a default file that sees every logical register and is charged one entry per rename, or the register's full cost when it is the owner. A file configured with a capacity of zero is unbounded and is never reported as full.

Dispatch presents the set of logical registers that an instruction group will write as a bit mask. In the same cycle the block returns a busy mask with one bit per file. Renames are charged through the allocate port and retirements are refunded through the release port. Writes that need no physical register, such as zero idioms and bypassed moves, are neither charged nor refunded.

The block also decides, one candidate per cycle, whether a register-to-register move may be removed at rename. The decision respects three conditions:
- the destination must be marked as an eligible move target;
- the destination's owning file has a cap on eliminations per cycle, where a cap of zero means no cap, and a cycle-start pulse clears the count;
- a file can be restricted to removing only moves whose source is known to hold zero.

One bit per logical register tracks that known-zero state.

Top module: `rename_budget_tracker`

## Requirements
- R1: After a synchronous reset, every used counter reads 0, the error flag is low, every per-cycle elimination count is 0, and no logical register is marked known-zero.
- R2: A charged allocation adds the register's cost to its owning file. It also adds 1 to file 0 when the owner is not file 0. A register owned by file 0 adds only its cost to file 0. With the defaults, logical registers 0-3 belong to file 0, 4-7 to file 1, 8-11 to file 2 and 12-15 to file 3. All cost 1 except 8-11, which cost 2.
- R3: An allocation flagged as producing zero, or as coming from an eliminated move, charges nothing. A release flagged as matching such a write refunds nothing.
- R4: An allocation and a release in the same cycle are netted per file before the counters update.
- R5: A release larger than a file's used count clamps that counter to 0 and sets a sticky error flag that stays high until reset.
- R6: Busy bit f is high, in the same cycle as the query, exactly when file f has a nonzero capacity and its used count plus the charge of all masked registers exceeds that capacity. A total equal to the capacity is not busy. With the defaults, the capacities are 0, 6, 8 and 4 for files 0 to 3.
- R7: A file with capacity 0 never raises its busy bit, whatever its count or the query.
- R8: A move is granted only when the destination register is flagged eligible. With the defaults, register 7 is the only ineligible one.
- R9: A file with a nonzero per-cycle limit grants moves only while its count for the current cycle is below the limit. A limit of 0 grants without bound. With the defaults, the limits are 0, 2, 1 and 1 for files 0 to 3.
- R10: A cycle-start pulse clears every elimination count. A move presented together with the pulse is judged against a count of 0 and counts toward the new cycle.
- R11: In a file restricted to zero moves (file 3 by default), a move is granted only if its source is known-zero.
- R12: Each allocation not flagged as an eliminated move sets or clears the written register's known-zero bit according to its zero flag. Eliminated writes leave the bit unchanged. The mv_zero output is high exactly when a move is granted and its source is known-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_start | input | 1 | Marks the first cycle of a new dispatch cycle |
| q_mask | input | NL | Logical registers a dispatch group would write |
| busy_mask | output | NF | Per-file lack of room for the queried group |
| alloc_valid | input | 1 | Register write being renamed |
| alloc_lreg | input | log2(NL) | Logical register written |
| alloc_zero | input | 1 | Write produces zero (no charge) |
| alloc_elim | input | 1 | Write comes from an eliminated move (no charge) |
| rel_valid | input | 1 | Write retiring |
| rel_lreg | input | log2(NL) | Logical register of the retiring write |
| rel_none | input | 1 | Retiring write had been charged nothing |
| mv_valid | input | 1 | Move-elimination candidate present |
| mv_src | input | log2(NL) | Move source register |
| mv_dst | input | log2(NL) | Move destination register |
| mv_grant | output | 1 | Move may be eliminated |
| mv_zero | output | 1 | Granted move copies a known-zero register |
| used_flat | output | NF*CNT_W | Used counters, file f at bits f*CNT_W upward |
| err | output | 1 | Sticky release-underflow flag |

## Verification
The bench drives each capacity to exactly full and to one entry beyond it. A design with an off-by-one compare would flag a file that still has room, or would pass a group it cannot hold. It nets an allocation against a release in the same cycle. A design that applies only one of the two would drift the counters of file 2 and file 0. It issues moves back to back across cycle-start pulses, including one that arrives with the pulse. A design that clears the count a cycle late, or that caps file 0, would deny a legal move. It also checks that a zero-only file tracks the known-zero bit through zero writes, eliminated writes and plain writes. A design that lets eliminated writes clear the bit would refuse a move the core could have removed.

// File: rtl/rbt_pkg.sv
package rbt_pkg;

    // Physical entries that a rename of a register owned by `owner` with
    // `cost` takes from file `file`; file 0 sees every logical register.
    function automatic int unsigned lreg_charge(int unsigned file,
                                                int unsigned owner,
                                                int unsigned cost);
        if (owner == file) return cost;
        if (file == 0) return 1;
        return 0;
    endfunction

endpackage

// File: rtl/rbt_file_ctr.sv
module rbt_file_ctr #(
    parameter int CNT_W = 6,
    parameter int SUM_W = 12,
    parameter logic [CNT_W-1:0] CAP = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] add_c,
    input  logic [CNT_W-1:0] sub_c,
    input  logic [SUM_W-1:0] need,
    output logic [CNT_W-1:0] used,
    output logic             busy,
    output logic             under
);
    logic [CNT_W:0]   gross;
    logic [CNT_W-1:0] used_nxt;

    always_comb begin
        gross    = {1'b0, used} + {1'b0, add_c};
        under    = gross < {1'b0, sub_c};
        used_nxt = under ? '0 : CNT_W'(gross - {1'b0, sub_c});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) used <= '0;
        else        used <= used_nxt;
    end

    if (CAP == '0) begin : g_unbounded
        assign busy = 1'b0;
    end else begin : g_bounded
        logic [SUM_W:0] total;
        assign total = (SUM_W+1)'(used) + (SUM_W+1)'(need);
        assign busy  = total > (SUM_W+1)'(CAP);
    end

endmodule

// File: rtl/rbt_elim_ctr.sv
module rbt_elim_ctr #(
    parameter int LIM_W = 3,
    parameter logic [LIM_W-1:0] LIMIT = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cycle_start,
    input  logic take,
    output logic room
);
    logic [LIM_W-1:0] cnt;
    logic [LIM_W-1:0] base;

    assign base = cycle_start ? '0 : cnt;
    assign room = (LIMIT == '0) || (base < LIMIT);

    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (take && base != '1)  cnt <= base + LIM_W'(1);
        else                          cnt <= base;
    end

endmodule

// File: rtl/rbt_zero_bits.sv
module rbt_zero_bits #(
    parameter int NL = 16,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [LW-1:0] wr_idx,
    input  logic          wr_zero,
    input  logic [LW-1:0] rd_idx,
    output logic          rd_zero
);
    logic [NL-1:0] zbits;

    always_ff @(posedge clk) begin
        if (!rst_n)     zbits <= '0;
        else if (wr_en) zbits[wr_idx] <= wr_zero;
    end

    assign rd_zero = zbits[rd_idx];

endmodule

// File: rtl/rename_budget_tracker.sv
module rename_budget_tracker #(
    parameter int NF     = 4,
    parameter int NL     = 16,
    parameter int CNT_W  = 6,
    parameter int COST_W = 2,
    parameter int LIM_W  = 3,
    parameter int FW     = $clog2(NF),
    parameter int LW     = $clog2(NL),
    parameter logic [NF*CNT_W-1:0] FILE_CAP   = {6'd4, 6'd8, 6'd6, 6'd0},
    parameter logic [NF*LIM_W-1:0] MV_LIMIT   = {3'd1, 3'd1, 3'd2, 3'd0},
    parameter logic [NF-1:0]       ZERO_ONLY  = 4'b1000,
    parameter logic [NL*FW-1:0]    LREG_OWNER = 32'hFFAA_5500,
    parameter logic [NL*COST_W-1:0] LREG_COST = 32'h55AA_5555,
    parameter logic [NL-1:0]       MV_OK      = 16'hFF7F
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cycle_start,
    input  logic [NL-1:0]       q_mask,
    output logic [NF-1:0]       busy_mask,
    input  logic                alloc_valid,
    input  logic [LW-1:0]       alloc_lreg,
    input  logic                alloc_zero,
    input  logic                alloc_elim,
    input  logic                rel_valid,
    input  logic [LW-1:0]       rel_lreg,
    input  logic                rel_none,
    input  logic                mv_valid,
    input  logic [LW-1:0]       mv_src,
    input  logic [LW-1:0]       mv_dst,
    output logic                mv_grant,
    output logic                mv_zero,
    output logic [NF*CNT_W-1:0] used_flat,
    output logic                err
);
    import rbt_pkg::*;

    localparam int SUM_W = CNT_W + LW + COST_W;

    function automatic int unsigned owner_of(int unsigned r);
        return 32'(LREG_OWNER[r*FW +: FW]);
    endfunction

    function automatic int unsigned cost_of(int unsigned r);
        return 32'(LREG_COST[r*COST_W +: COST_W]);
    endfunction

    logic          alloc_charged;
    logic          rel_charged;
    logic [NF-1:0] under;
    logic [NF-1:0] room;
    logic [FW-1:0] mv_file;
    logic          src_zero;

    assign alloc_charged = alloc_valid && !alloc_zero && !alloc_elim;
    assign rel_charged   = rel_valid && !rel_none;

    for (genvar f = 0; f < NF; f++) begin : g_file
        logic [SUM_W-1:0] need;
        logic [CNT_W-1:0] add_c;
        logic [CNT_W-1:0] sub_c;
        logic [CNT_W-1:0] used;

        always_comb begin
            need = '0;
            for (int r = 0; r < NL; r++) begin
                if (q_mask[r])
                    need = need + SUM_W'(lreg_charge(f, owner_of(r), cost_of(r)));
            end
            add_c = '0;
            if (alloc_charged)
                add_c = CNT_W'(lreg_charge(f, owner_of(32'(alloc_lreg)),
                                           cost_of(32'(alloc_lreg))));
            sub_c = '0;
            if (rel_charged)
                sub_c = CNT_W'(lreg_charge(f, owner_of(32'(rel_lreg)),
                                           cost_of(32'(rel_lreg))));
        end

        rbt_file_ctr #(
            .CNT_W (CNT_W),
            .SUM_W (SUM_W),
            .CAP   (FILE_CAP[f*CNT_W +: CNT_W])
        ) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .add_c (add_c),
            .sub_c (sub_c),
            .need  (need),
            .used  (used),
            .busy  (busy_mask[f]),
            .under (under[f])
        );

        rbt_elim_ctr #(
            .LIM_W (LIM_W),
            .LIMIT (MV_LIMIT[f*LIM_W +: LIM_W])
        ) u_elim (
            .clk         (clk),
            .rst_n       (rst_n),
            .cycle_start (cycle_start),
            .take        (mv_grant && (mv_file == FW'(f))),
            .room        (room[f])
        );

        assign used_flat[f*CNT_W +: CNT_W] = used;
    end

    rbt_zero_bits #(
        .NL (NL),
        .LW (LW)
    ) u_zero (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (alloc_valid && !alloc_elim),
        .wr_idx  (alloc_lreg),
        .wr_zero (alloc_zero),
        .rd_idx  (mv_src),
        .rd_zero (src_zero)
    );

    assign mv_file  = LREG_OWNER[32'(mv_dst)*FW +: FW];
    assign mv_grant = mv_valid && MV_OK[mv_dst] && room[mv_file]
                      && (!ZERO_ONLY[mv_file] || src_zero);
    assign mv_zero  = mv_grant && src_zero;

    always_ff @(posedge clk) begin
        if (!rst_n)      err <= 1'b0;
        else if (|under) err <= 1'b1;
    end

endmodule

// File: rtl/rename_budget_tracker_chk.sv
module rename_budget_tracker_chk #(
    parameter int NF    = 4,
    parameter int NL    = 16,
    parameter int CNT_W = 6,
    parameter int FW    = 2,
    parameter int LW    = 4,
    parameter logic [NF*CNT_W-1:0] FILE_CAP   = '0,
    parameter logic [NF-1:0]       ZERO_ONLY  = '0,
    parameter logic [NL*FW-1:0]    LREG_OWNER = '0,
    parameter logic [NL-1:0]       MV_OK      = '0
) (
    input logic                clk,
    input logic                rst_n,
    input logic                alloc_valid,
    input logic                alloc_zero,
    input logic                alloc_elim,
    input logic                rel_valid,
    input logic                mv_valid,
    input logic [LW-1:0]       mv_dst,
    input logic                mv_grant,
    input logic                mv_zero,
    input logic [NF-1:0]       busy_mask,
    input logic [NF*CNT_W-1:0] used_flat,
    input logic                err
);
    logic [FW-1:0] dst_file;
    assign dst_file = LREG_OWNER[32'(mv_dst)*FW +: FW];

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (used_flat == '0 && !err));

    // R3
    a_r3_no_charge: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && (alloc_zero || alloc_elim) && !rel_valid)
        |=> used_flat == $past(used_flat));

    // R5
    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R8
    a_r8_eligible_dst: assert property (@(posedge clk) disable iff (!rst_n)
        mv_grant |-> (mv_valid && MV_OK[mv_dst]));

    // R11
    a_r11_zero_only_src: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_grant && ZERO_ONLY[dst_file]) |-> mv_zero);

    // R12
    a_r12_zero_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        mv_zero |-> mv_grant);

    for (genvar f = 0; f < NF; f++) begin : g_unl
        if (FILE_CAP[f*CNT_W +: CNT_W] == '0) begin : g_chk
            // R7
            a_r7_unbounded_free: assert property (@(posedge clk) disable iff (!rst_n)
                !busy_mask[f]);
        end
    end

endmodule

bind rename_budget_tracker rename_budget_tracker_chk #(
    .NF         (NF),
    .NL         (NL),
    .CNT_W      (CNT_W),
    .FW         (FW),
    .LW         (LW),
    .FILE_CAP   (FILE_CAP),
    .ZERO_ONLY  (ZERO_ONLY),
    .LREG_OWNER (LREG_OWNER),
    .MV_OK      (MV_OK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_valid (alloc_valid),
    .alloc_zero  (alloc_zero),
    .alloc_elim  (alloc_elim),
    .rel_valid   (rel_valid),
    .mv_valid    (mv_valid),
    .mv_dst      (mv_dst),
    .mv_grant    (mv_grant),
    .mv_zero     (mv_zero),
    .busy_mask   (busy_mask),
    .used_flat   (used_flat),
    .err         (err)
);

// File: tb/test_rename_budget_tracker.sv
module test_rename_budget_tracker;
    localparam int NF = 4;
    localparam int NL = 16;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cycle_start;
    logic [NL-1:0] q_mask;
    logic [NF-1:0] busy_mask;
    logic          alloc_valid, alloc_zero, alloc_elim;
    logic [3:0]    alloc_lreg;
    logic          rel_valid, rel_none;
    logic [3:0]    rel_lreg;
    logic          mv_valid;
    logic [3:0]    mv_src, mv_dst;
    logic          mv_grant, mv_zero;
    logic [NF*CW-1:0] used_flat;
    logic          err;

    always #4 clk = ~clk;   // 125 MHz

    rename_budget_tracker i_rename_budget_tracker (.*);

    typedef struct {
        string req;
        int    sel;   // 0 used[idx], 1 busy, 2 grant, 3 zero, 4 err
        int    idx;
        int    exp;
    } item_t;

    item_t sb[$];
    int n_chk  = 0;
    int n_fail = 0;
    int mdl[NF];
    bit done = 0;

    // Expected charge, written from R2.
    function automatic int charge(int f, int r);
        int own  = r / 4;
        int cost = (own == 2) ? 2 : 1;
        if (own == f) return cost;
        if (f == 0)   return 1;
        return 0;
    endfunction

    function automatic int actual(int sel, int idx);
        case (sel)
            0:       return int'(used_flat[idx*CW +: CW]);
            1:       return int'(busy_mask);
            2:       return int'(mv_grant);
            3:       return int'(mv_zero);
            default: return int'(err);
        endcase
    endfunction

    task automatic expect_item(string req, int sel, int idx, int exp);
        item_t it;
        it.req = req; it.sel = sel; it.idx = idx; it.exp = exp;
        sb.push_back(it);
    endtask

    // Monitor: compares queued expectations against the outputs.
    initial begin : monitor
        forever begin
            item_t it;
            int act;
            wait (sb.size() != 0);
            it  = sb.pop_front();
            act = actual(it.sel, it.idx);
            n_chk++;
            if (act != it.exp) begin
                n_fail++;
                $display("FAIL %s sel=%0d idx=%0d: actual %0d expected %0d",
                         it.req, it.sel, it.idx, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        cycle_start = 0; q_mask = '0;
        alloc_valid = 0; alloc_lreg = '0; alloc_zero = 0; alloc_elim = 0;
        rel_valid = 0; rel_lreg = '0; rel_none = 0;
        mv_valid = 0; mv_src = '0; mv_dst = '0;
    endtask

    task automatic model_add(int r, int sign);
        for (int f = 0; f < NF; f++) begin
            mdl[f] = mdl[f] + sign * charge(f, r);
            if (mdl[f] < 0) mdl[f] = 0;
        end
    endtask

    task automatic chk_used(string req);
        for (int f = 0; f < NF; f++) expect_item(req, 0, f, mdl[f]);
    endtask

    task automatic wr(int r, bit z, bit e);
        alloc_valid = 1; alloc_lreg = 4'(r); alloc_zero = z; alloc_elim = e;
        if (!z && !e) model_add(r, 1);
        step();
        idle();
    endtask

    task automatic wr_rel(int ar, int fr);
        alloc_valid = 1; alloc_lreg = 4'(ar);
        rel_valid = 1; rel_lreg = 4'(fr);
        model_add(ar, 1);
        model_add(fr, -1);
        step();
        idle();
    endtask

    task automatic query(string req, logic [NL-1:0] m, int exp);
        q_mask = m;
        #1;
        expect_item(req, 1, 0, exp);
        #1;
        q_mask = '0;
    endtask

    task automatic try_mv(string req, bit cs, int s, int d, int eg, int ez);
        cycle_start = cs; mv_valid = 1; mv_src = 4'(s); mv_dst = 4'(d);
        #1;
        expect_item(req, 2, 0, eg);
        expect_item(req, 3, 0, ez);
        step();
        idle();
    endtask

    initial begin : watchdog
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : driver
        for (int f = 0; f < NF; f++) mdl[f] = 0;
        idle();
        rst_n = 0;
        repeat (3) step();
        rst_n = 1;

        // R1: reset state
        chk_used("R1");
        expect_item("R1", 4, 0, 0);
        query("R1", '0, 0);
        try_mv("R1 known-zero clear", 1, 12, 13, 0, 0);

        // R2: charging per owner and file 0
        wr(5, 0, 0);
        wr(9, 0, 0);
        wr(2, 0, 0);
        chk_used("R2");

        // R3: uncharged writes and releases
        wr(9, 1, 0);
        wr(10, 0, 1);
        rel_valid = 1; rel_lreg = 4'(9); rel_none = 1;
        step(); idle();
        chk_used("R3");

        // R4: same-cycle netting
        wr_rel(9, 8);
        chk_used("R4 equal");
        wr_rel(4, 9);
        chk_used("R4 cross-file");

        // R6 / R7: busy mask boundaries
        wr(4, 0, 0);                        // f1 = 3
        query("R6 file1 full",  16'hFFFF, 2);
        query("R6 file1 equal", 16'h0070, 0);
        wr(8, 0, 0);                        // f2 = 2
        query("R6 file2 over",  16'h0F00, 4);
        query("R6 file2 equal", 16'h0E00, 0);
        query("R7 file0 never", 16'hFFFF, 6);

        // R5: underflow clamps and sticks
        rel_valid = 1; rel_lreg = 4'(12);
        model_add(12, -1);
        step(); idle();
        chk_used("R5 clamp");
        expect_item("R5 set", 4, 0, 1);
        step();
        expect_item("R5 sticky", 4, 0, 1);

        // R8: ineligible destination
        try_mv("R8", 1, 5, 7, 0, 0);

        // R9 / R10: per-cycle limit
        try_mv("R9 first",  1, 4, 5, 1, 0);
        try_mv("R9 second", 0, 4, 6, 1, 0);
        try_mv("R9 capped", 0, 4, 5, 0, 0);
        try_mv("R10 with pulse", 1, 4, 5, 1, 0);
        try_mv("R10 counts", 0, 4, 6, 1, 0);
        try_mv("R10 capped", 0, 4, 5, 0, 0);
        try_mv("R9 nocap a", 0, 1, 2, 1, 0);
        try_mv("R9 nocap b", 0, 1, 3, 1, 0);
        try_mv("R9 nocap c", 0, 1, 2, 1, 0);

        // R11 / R12: zero-only file and known-zero bits
        try_mv("R11 nonzero src", 1, 12, 13, 0, 0);
        wr(12, 1, 0);
        try_mv("R11 zero src", 1, 12, 13, 1, 1);
        try_mv("R12 plain move", 1, 4, 5, 1, 0);
        wr(12, 0, 1);
        try_mv("R12 elim keeps bit", 1, 12, 14, 1, 1);
        wr(12, 0, 0);
        try_mv("R12 plain clears", 1, 12, 14, 0, 0);
        chk_used("R12 charge");

        wait (sb.size() == 0);
        #1;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule